// File: doc/BRIEF.md
# Page-Protected Memory Write Controller

This block is a byte-addressed controller in front of a data array split into equal pages and a small register page. Each data page has a protection byte in the register page. That byte decides what happens to writes aimed at the page. A write may be stored as given, dropped, or reduced to clearing bits, so the stored byte becomes the AND of the old byte and the new data.

Protection bytes are write-once, and so is a single lock byte. Once a protection byte or the lock byte holds one of the two sealing codes (55h or AAh), it cannot be written again. A sealed lock byte also freezes every protection byte. The rest of the register page holds read-only factory bytes and reserved locations.

A client drives an address, write data and single-cycle read and write strobes. A read returns its byte one clock after the strobe. A one-cycle acknowledge, registered after each write strobe, tells the client whether the write changed storage.

Top module: `pgprot_mem_ctrl`

## Requirements
- R1: A write to a data byte whose page protection byte holds neither 55h nor AAh stores the write data. wr_ack is high in the cycle after the strobe. A read strobe makes rdata show the addressed byte in the cycle after the strobe, and rdata holds its value while rd_en is low.
- R2: After reset, every data byte, every protection byte and the lock byte read FFh, while rdata and wr_ack are 0.
- R3: When the protection byte of a page holds 55h, writes to that page leave it unchanged and wr_ack stays low.
- R4: When the protection byte of a page holds AAh, a write to that page stores the old byte ANDed with the write data, and wr_ack is high.
- R5: A protection byte holding 55h or AAh rejects further writes: its value is kept and wr_ack stays low.
- R6: Any other value written to a protection byte is stored, leaves its page writable, and can be overwritten.
- R7: The lock byte sits at the address right after the last protection byte. While it holds a value other than 55h or AAh it is writable. Once it holds 55h or AAh, it and all protection bytes reject writes.
- R8: The identity byte, right after the lock byte, reads FACTORY_ID. The last two bytes of the register page read FACTORY_TAIL0 (even address) and FACTORY_TAIL1 (odd address). Writes to these three bytes are rejected with wr_ack low.
- R9: The reserved bytes between the identity byte and the factory tail, and every address past the register page, read 00h. Writes to them are rejected with wr_ack low.
- R10: Protection byte n governs only data page n. Sealing one page leaves its neighbours writable.
- R11: When a read and a write strike the same address in one cycle, the read returns the byte as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, one cycle after rd_en |
| wr_ack | output | 1 | High one cycle after a write that changed storage |

## Verification
The bench builds the block with the default geometry of 16 pages of 32 bytes, which places the protection bytes at 200h and the lock byte at 210h. It overrides FACTORY_ID to AAh, so the identity byte is checked against a non-default value. With these values the bench reaches the last data byte, the reserved gap, the far end of the address space, and an AND-only page whose pattern clears some bits and keeps others.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  typedef enum logic [2:0] {
    RG_DATA,
    RG_PROT,
    RG_LOCK,
    RG_FID,
    RG_FTAIL,
    RG_VOID
  } region_e;

  localparam logic [7:0] CODE_BLOCK = 8'h55;
  localparam logic [7:0] CODE_CLEAR = 8'hAA;

  // a byte holding either sealing code is frozen
  function automatic logic is_seal(input logic [7:0] v);
    return (v == CODE_BLOCK) || (v == CODE_CLEAR);
  endfunction

endpackage

// File: rtl/pgprot_rst_sync.sv
module pgprot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/pgprot_decode.sv
module pgprot_decode
  import pgprot_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 16
) (
  input  logic [ADDR_W-1:0]                   addr,
  output region_e                             region,
  output logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] data_idx,
  output logic [$clog2(NUM_PAGES)-1:0]        dpage,
  output logic [$clog2(NUM_PAGES)-1:0]        rpage,
  output logic                                tail_odd
);

  localparam int DATA_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int DATA_W     = $clog2(DATA_BYTES);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int PG_W       = $clog2(NUM_PAGES);

  localparam logic [ADDR_W-1:0] REG_BASE  = ADDR_W'(DATA_BYTES);
  localparam logic [ADDR_W-1:0] REG_END   = ADDR_W'(DATA_BYTES + PAGE_BYTES);
  localparam logic [ADDR_W-1:0] OFF_LOCK  = ADDR_W'(NUM_PAGES);
  localparam logic [ADDR_W-1:0] OFF_FID   = ADDR_W'(NUM_PAGES + 1);
  localparam logic [ADDR_W-1:0] OFF_TAIL  = ADDR_W'(PAGE_BYTES - 2);
  localparam logic [ADDR_W-1:0] OFF_PROTN = ADDR_W'(NUM_PAGES);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off      = addr - REG_BASE;
    data_idx = addr[DATA_W-1:0];
    dpage    = addr[OFF_W+PG_W-1:OFF_W];
    rpage    = off[PG_W-1:0];
    tail_odd = off[0];

    if (addr < REG_BASE) begin
      region = RG_DATA;
    end else if (addr >= REG_END) begin
      region = RG_VOID;
    end else if (off < OFF_PROTN) begin
      region = RG_PROT;
    end else if (off == OFF_LOCK) begin
      region = RG_LOCK;
    end else if (off == OFF_FID) begin
      region = RG_FID;
    end else if (off >= OFF_TAIL) begin
      region = RG_FTAIL;
    end else begin
      region = RG_VOID;
    end
  end

endmodule

// File: rtl/pgprot_policy.sv
module pgprot_policy
  import pgprot_pkg::*;
(
  input  logic       wr_en,
  input  region_e    region,
  input  logic [7:0] cur_byte,
  input  logic [7:0] page_code,
  input  logic [7:0] lock_code,
  input  logic [7:0] wdata,
  output logic       commit,
  output logic [7:0] wval
);

  always_comb begin
    commit = 1'b0;
    wval   = wdata;
    unique case (region)
      RG_DATA: begin
        if (page_code == CODE_CLEAR) begin
          commit = wr_en;
          wval   = cur_byte & wdata;
        end else if (page_code != CODE_BLOCK) begin
          commit = wr_en;
        end
      end
      RG_PROT: commit = wr_en && !is_seal(lock_code) && !is_seal(cur_byte);
      RG_LOCK: commit = wr_en && !is_seal(cur_byte);
      default: commit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pgprot_store.sv
module pgprot_store #(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       we_data,
  input  logic                                       we_prot,
  input  logic                                       we_lock,
  input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0]    data_idx,
  input  logic [$clog2(NUM_PAGES)-1:0]               dpage,
  input  logic [$clog2(NUM_PAGES)-1:0]               rpage,
  input  logic [7:0]                                 wval,
  output logic [7:0]                                 data_byte,
  output logic [7:0]                                 page_code,
  output logic [7:0]                                 prot_byte,
  output logic [7:0]                                 lock_byte
);

  localparam int DATA_BYTES = PAGE_BYTES * NUM_PAGES;

  logic [7:0] mem_q  [DATA_BYTES];
  logic [7:0] prot_q [NUM_PAGES];
  logic [7:0] lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_data) begin
      mem_q[data_idx] <= wval;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PAGES; g++) begin : g_prot
      logic hit;
      assign hit = we_prot && (rpage == g[$clog2(NUM_PAGES)-1:0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prot_q[g] <= 8'hFF;
        end else if (hit) begin
          prot_q[g] <= wval;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 8'hFF;
    end else if (we_lock) begin
      lock_q <= wval;
    end
  end

  assign data_byte = mem_q[data_idx];
  assign page_code = prot_q[dpage];
  assign prot_byte = prot_q[rpage];
  assign lock_byte = lock_q;

endmodule

// File: rtl/pgprot_mem_ctrl.sv
module pgprot_mem_ctrl
  import pgprot_pkg::*;
#(
  parameter int         ADDR_W        = 10,
  parameter int         PAGE_BYTES    = 32,
  parameter int         NUM_PAGES     = 16,
  parameter logic [7:0] FACTORY_ID    = 8'h55,
  parameter logic [7:0] FACTORY_TAIL0 = 8'h5A,
  parameter logic [7:0] FACTORY_TAIL1 = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              wr_ack
);

  localparam int DATA_W = $clog2(PAGE_BYTES * NUM_PAGES);
  localparam int PG_W   = $clog2(NUM_PAGES);

  logic              srst_n;
  region_e           region;
  logic [DATA_W-1:0] data_idx;
  logic [PG_W-1:0]   dpage;
  logic [PG_W-1:0]   rpage;
  logic              tail_odd;
  logic [7:0]        data_byte;
  logic [7:0]        page_code;
  logic [7:0]        prot_byte;
  logic [7:0]        lock_byte;
  logic [7:0]        cur_byte;
  logic              commit;
  logic [7:0]        wval;
  logic [7:0]        rdata_d;
  logic              ack_d;

  pgprot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  pgprot_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
  ) u_dec (
    .addr     (addr),
    .region   (region),
    .data_idx (data_idx),
    .dpage    (dpage),
    .rpage    (rpage),
    .tail_odd (tail_odd)
  );

  pgprot_store #(
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
  ) u_store (
    .clk       (clk),
    .rst_n     (srst_n),
    .we_data   (commit && (region == RG_DATA)),
    .we_prot   (commit && (region == RG_PROT)),
    .we_lock   (commit && (region == RG_LOCK)),
    .data_idx  (data_idx),
    .dpage     (dpage),
    .rpage     (rpage),
    .wval      (wval),
    .data_byte (data_byte),
    .page_code (page_code),
    .prot_byte (prot_byte),
    .lock_byte (lock_byte)
  );

  // byte currently held at the address: read source and AND operand
  always_comb begin
    unique case (region)
      RG_DATA:  cur_byte = data_byte;
      RG_PROT:  cur_byte = prot_byte;
      RG_LOCK:  cur_byte = lock_byte;
      RG_FID:   cur_byte = FACTORY_ID;
      RG_FTAIL: cur_byte = tail_odd ? FACTORY_TAIL1 : FACTORY_TAIL0;
      default:  cur_byte = 8'h00;
    endcase
  end

  pgprot_policy u_pol (
    .wr_en     (wr_en),
    .region    (region),
    .cur_byte  (cur_byte),
    .page_code (page_code),
    .lock_code (lock_byte),
    .wdata     (wdata),
    .commit    (commit),
    .wval      (wval)
  );

  always_comb begin
    rdata_d = rd_en ? cur_byte : rdata;
    ack_d   = commit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata  <= 8'h00;
      wr_ack <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      wr_ack <= ack_d;
    end
  end

endmodule

// File: rtl/pgprot_mem_ctrl_chk.sv
module pgprot_mem_ctrl_chk #(
  parameter int         ADDR_W     = 10,
  parameter int         PAGE_BYTES = 32,
  parameter int         NUM_PAGES  = 16,
  parameter logic [7:0] FACTORY_ID = 8'h55
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              wr_ack
);

  localparam logic [31:0] BASE    = 32'(PAGE_BYTES * NUM_PAGES);
  localparam logic [31:0] A_FID   = BASE + 32'(NUM_PAGES + 1);
  localparam logic [31:0] A_TAIL  = BASE + 32'(PAGE_BYTES - 2);
  localparam logic [31:0] A_END   = BASE + 32'(PAGE_BYTES);

  logic [31:0] a;
  logic        is_void;
  logic        is_fact;

  assign a       = 32'(addr);
  assign is_void = (a >= A_END) || ((a > A_FID) && (a < A_TAIL));
  assign is_fact = (a == A_FID) || ((a >= A_TAIL) && (a < A_END));

  AST_ACK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_ack); // R1
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R1
  AST_VOID_WRITE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_void) |=> !wr_ack); // R9
  AST_VOID_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_void) |=> (rdata == 8'h00)); // R9
  AST_FACTORY_WRITE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_fact) |=> !wr_ack); // R8
  AST_FACTORY_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (a == A_FID)) |=> (rdata == FACTORY_ID)); // R8

endmodule

bind pgprot_mem_ctrl pgprot_mem_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .NUM_PAGES  (NUM_PAGES),
  .FACTORY_ID (FACTORY_ID)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .rdata  (rdata),
  .wr_ack (wr_ack)
);

// File: tb/test_pgprot_mem_ctrl.sv
module test_pgprot_mem_ctrl;

  localparam int         ADDR_W = 10;
  localparam logic [7:0] FID    = 8'hAA;
  localparam logic [7:0] TAIL0  = 8'h5A;
  localparam logic [7:0] TAIL1  = 8'hA5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = 8'h00;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [7:0]        rdata;
  logic              wr_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pgprot_mem_ctrl #(
    .ADDR_W     (ADDR_W),
    .FACTORY_ID (FID)
  ) i_pgprot_mem_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (wdata),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .wr_ack (wr_ack)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // write strobe for one cycle, then sample the acknowledge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                    input logic exp_ack, input string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, {7'b0, wr_ack}, {7'b0, exp_ack});
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic t_reset;
    check("R2 rdata", rdata, 8'h00);
    check("R2 ack", {7'b0, wr_ack}, 8'h00);
    rd(10'h000, 8'hFF, "R2 data");
    rd(10'h1FF, 8'hFF, "R2 data last");
    rd(10'h20F, 8'hFF, "R2 prot");
    rd(10'h210, 8'hFF, "R2 lock");
  endtask

  task automatic t_plain;
    wr(10'h005, 8'h3C, 1'b1, "R1 ack");
    rd(10'h005, 8'h3C, "R1 data");
    wr(10'h1FF, 8'hC3, 1'b1, "R1 ack last");
    rd(10'h1FF, 8'hC3, "R1 last byte");
    @(negedge clk); addr = 10'h005;
    @(negedge clk);
    check("R1 hold", rdata, 8'hC3);
  endtask

  task automatic t_block;
    wr(10'h203, 8'h55, 1'b1, "R3 seal");
    wr(10'h060, 8'h12, 1'b0, "R3 ack");
    rd(10'h060, 8'hFF, "R3 data");
    wr(10'h07F, 8'h00, 1'b0, "R3 ack end");
    wr(10'h080, 8'h77, 1'b1, "R10 ack");
    rd(10'h080, 8'h77, "R10 neighbour");
    wr(10'h203, 8'h00, 1'b0, "R5 ack");
    rd(10'h203, 8'h55, "R5 kept");
  endtask

  task automatic t_clear;
    wr(10'h0A0, 8'hF0, 1'b1, "R4 prefill");
    wr(10'h205, 8'hAA, 1'b1, "R4 seal");
    wr(10'h0A0, 8'h3C, 1'b1, "R4 ack");
    rd(10'h0A0, 8'h30, "R4 and");
    wr(10'h0A0, 8'hFF, 1'b1, "R4 ack ff");
    rd(10'h0A0, 8'h30, "R4 no set");
    wr(10'h205, 8'h00, 1'b0, "R5 aa ack");
    rd(10'h205, 8'hAA, "R5 aa kept");
  endtask

  task automatic t_other;
    wr(10'h206, 8'h12, 1'b1, "R6 ack");
    rd(10'h206, 8'h12, "R6 stored");
    wr(10'h0C0, 8'h99, 1'b1, "R6 page ack");
    rd(10'h0C0, 8'h99, "R6 page data");
    wr(10'h206, 8'h34, 1'b1, "R6 rewrite");
    rd(10'h206, 8'h34, "R6 rewritten");
  endtask

  task automatic t_lock;
    wr(10'h210, 8'h3C, 1'b1, "R7 plain ack");
    rd(10'h210, 8'h3C, "R7 plain");
    wr(10'h207, 8'h01, 1'b1, "R7 before");
    wr(10'h210, 8'hAA, 1'b1, "R7 seal");
    wr(10'h207, 8'h02, 1'b0, "R7 frozen ack");
    rd(10'h207, 8'h01, "R7 frozen");
    wr(10'h210, 8'h00, 1'b0, "R7 lock ack");
    rd(10'h210, 8'hAA, "R7 lock kept");
    wr(10'h0E0, 8'h44, 1'b1, "R7 data open");
  endtask

  task automatic t_factory;
    rd(10'h211, FID, "R8 id");
    rd(10'h21E, TAIL0, "R8 tail0");
    rd(10'h21F, TAIL1, "R8 tail1");
    wr(10'h211, 8'h00, 1'b0, "R8 id ack");
    wr(10'h21F, 8'h00, 1'b0, "R8 tail ack");
    rd(10'h211, FID, "R8 id kept");
    rd(10'h21F, TAIL1, "R8 tail kept");
  endtask

  task automatic t_void;
    rd(10'h212, 8'h00, "R9 rsvd lo");
    rd(10'h21D, 8'h00, "R9 rsvd hi");
    wr(10'h215, 8'h77, 1'b0, "R9 rsvd ack");
    rd(10'h215, 8'h00, "R9 rsvd kept");
    rd(10'h220, 8'h00, "R9 past page");
    wr(10'h3FF, 8'h77, 1'b0, "R9 top ack");
    rd(10'h3FF, 8'h00, "R9 top");
  endtask

  task automatic t_same;
    @(negedge clk);
    addr = 10'h010; wdata = 8'h5A; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 old", rdata, 8'hFF);
    check("R11 ack", {7'b0, wr_ack}, 8'h01);
    rd(10'h010, 8'h5A, "R11 new");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_plain;
    t_block;
    t_clear;
    t_other;
    t_lock;
    t_factory;
    t_void;
    t_same;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule